// File: doc/BRIEF.md
# Accumulator and Extension-Bit Logic Unit

This block is the arithmetic and logic core of a 16-bit machine that has a single accumulator. It holds the accumulator register and a one-bit extension flag. The accumulator can change only through this unit. Each clock, a controller may assert one line of a one-hot command vector. The unit then updates the accumulator and the extension bit from their own values, from a 16-bit data operand, or from an 8-bit input byte.

The unit also drives four registered condition flags: accumulator positive, accumulator negative, accumulator zero and extension zero. The controller uses these flags to decide whether to skip the next instruction. Memory, bus routing and instruction decoding are outside the block.

Top module: `acc_logic_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the unit clears the accumulator and the extension bit. After that edge, `flag_pos`, `flag_acz` and `flag_ez` read 1 and `flag_neg` reads 0.
- R2: With `op_cmd` all zero, the accumulator and the extension bit keep their values.
- R3: Command bit 0 clears the accumulator. Command bit 1 clears the extension bit. Each leaves the other register unchanged.
- R4: Command bit 2 inverts every accumulator bit. Command bit 3 inverts the extension bit.
- R5: Command bit 4 rotates right through the extension bit. The accumulator shifts toward bit 0, the old extension bit enters bit 15, and the old bit 0 becomes the new extension bit.
- R6: Command bit 5 rotates left through the extension bit. The accumulator shifts toward bit 15, the old extension bit enters bit 0, and the old bit 15 becomes the new extension bit.
- R7: Command bit 6 adds one to the accumulator modulo 2^16. The extension bit is unchanged.
- R8: Command bit 7 replaces the accumulator with the bitwise AND of the accumulator and `dr_in`. The extension bit is unchanged.
- R9: Command bit 8 replaces the accumulator with the low 16 bits of the accumulator plus `dr_in`, and writes the carry out of bit 15 into the extension bit.
- R10: Command bit 9 copies `dr_in` into the accumulator unchanged. The extension bit is unchanged.
- R11: Command bit 10 loads `inp_in` into accumulator bits 7..0. Bits 15..8 and the extension bit are unchanged.
- R12: At every clock, `flag_pos` equals the inverse of accumulator bit 15, `flag_neg` equals bit 15, `flag_acz` is 1 exactly when the accumulator is zero, and `flag_ez` is 1 exactly when the extension bit is zero.
- R13: At most one `op_cmd` bit is high in any cycle. Every command takes effect at the rising edge where it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_cmd | input | 11 | One-hot operation command |
| dr_in | input | 16 | Data operand |
| inp_in | input | 8 | Input byte |
| ac_out | output | 16 | Accumulator |
| e_out | output | 1 | Extension bit |
| flag_pos | output | 1 | Accumulator bit 15 is 0 |
| flag_neg | output | 1 | Accumulator bit 15 is 1 |
| flag_acz | output | 1 | Accumulator is zero |
| flag_ez | output | 1 | Extension bit is zero |

## Verification
The accumulator and the extension bit are both visible at the ports. A wrong update therefore shows up one clock after the offending command, in `ac_out`, in `e_out` or in a flag. The bench chains commands so that each result feeds the next one. For example, a rotate moves a bit into the extension flag and a later rotate or add brings it back out. An error that lands only in the extension bit is exposed within a few commands even when `flag_ez` happens to match. The four flags are registered separately from the accumulator, so the bench compares them against the accumulator model on every scoreboard item.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned OP_CLR_AC = 0;
  localparam int unsigned OP_CLR_E  = 1;
  localparam int unsigned OP_CMP_AC = 2;
  localparam int unsigned OP_CMP_E  = 3;
  localparam int unsigned OP_ROR    = 4;
  localparam int unsigned OP_ROL    = 5;
  localparam int unsigned OP_INC    = 6;
  localparam int unsigned OP_AND    = 7;
  localparam int unsigned OP_ADD    = 8;
  localparam int unsigned OP_LOAD   = 9;
  localparam int unsigned OP_INP    = 10;
  localparam int unsigned NUM_OPS   = 11;

  typedef struct packed {
    logic pos;
    logic neg;
    logic acz;
    logic ez;
  } cond_flags_t;
endpackage

// File: rtl/acc_bitops.sv
module acc_bitops #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 8
) (
  input  logic [W-1:0]  ac,
  input  logic          e,
  input  logic [W-1:0]  dr,
  input  logic [IW-1:0] inp,
  output logic [W-1:0]  ac_not,
  output logic [W-1:0]  ac_and,
  output logic [W-1:0]  ac_ror,
  output logic          e_ror,
  output logic [W-1:0]  ac_rol,
  output logic          e_rol,
  output logic [W-1:0]  ac_inp
);
  localparam int unsigned HI = W - IW;

  assign ac_not = ~ac;
  assign ac_and = ac & dr;
  assign ac_ror = {e, ac[W-1:1]};
  assign e_ror  = ac[0];
  assign ac_rol = {ac[W-2:0], e};
  assign e_rol  = ac[W-1];

  generate
    if (HI > 0) begin : g_merge
      assign ac_inp = {ac[W-1:IW], inp};
    end else begin : g_full
      assign ac_inp = inp[W-1:0];
    end
  endgenerate
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] ac,
  input  logic [W-1:0] dr,
  input  logic         use_one,
  output logic [W-1:0] sum,
  output logic         carry
);
  logic [W-1:0] operand;
  logic [W:0]   full;

  assign operand = use_one ? W'(1) : dr;
  assign full    = {1'b0, ac} + {1'b0, operand};
  assign sum     = full[W-1:0];
  assign carry   = full[W];
endmodule

// File: rtl/acc_flags.sv
module acc_flags #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]        ac,
  input  logic                e,
  output acc_pkg::cond_flags_t flags
);
  always_comb begin
    flags.pos = ~ac[W-1];
    flags.neg = ac[W-1];
    flags.acz = (ac == '0);
    flags.ez  = ~e;
  end
endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [acc_pkg::NUM_OPS-1:0] op_cmd,
  input  logic [W-1:0]                dr_in,
  input  logic [IW-1:0]               inp_in,
  output logic [W-1:0]                ac_out,
  output logic                        e_out,
  output logic                        flag_pos,
  output logic                        flag_neg,
  output logic                        flag_acz,
  output logic                        flag_ez
);
  import acc_pkg::*;

  logic [W-1:0] ac_q, ac_nx;
  logic         e_q, e_nx;
  cond_flags_t  flg_q, flg_nx;

  logic [W-1:0] r_not, r_and, r_ror, r_rol, r_inp, r_sum;
  logic         e_ror, e_rol, r_carry;

  acc_bitops #(.W(W), .IW(IW)) u_bitops (
    .ac(ac_q), .e(e_q), .dr(dr_in), .inp(inp_in),
    .ac_not(r_not), .ac_and(r_and),
    .ac_ror(r_ror), .e_ror(e_ror),
    .ac_rol(r_rol), .e_rol(e_rol),
    .ac_inp(r_inp)
  );

  acc_adder #(.W(W)) u_adder (
    .ac(ac_q), .dr(dr_in), .use_one(op_cmd[OP_INC]),
    .sum(r_sum), .carry(r_carry)
  );

  always_comb begin
    ac_nx = ac_q;
    e_nx  = e_q;
    if (op_cmd[OP_CLR_AC]) ac_nx = '0;
    if (op_cmd[OP_CLR_E])  e_nx  = 1'b0;
    if (op_cmd[OP_CMP_AC]) ac_nx = r_not;
    if (op_cmd[OP_CMP_E])  e_nx  = ~e_q;
    if (op_cmd[OP_ROR]) begin
      ac_nx = r_ror;
      e_nx  = e_ror;
    end
    if (op_cmd[OP_ROL]) begin
      ac_nx = r_rol;
      e_nx  = e_rol;
    end
    if (op_cmd[OP_INC])  ac_nx = r_sum;
    if (op_cmd[OP_AND])  ac_nx = r_and;
    if (op_cmd[OP_ADD]) begin
      ac_nx = r_sum;
      e_nx  = r_carry;
    end
    if (op_cmd[OP_LOAD]) ac_nx = dr_in;
    if (op_cmd[OP_INP])  ac_nx = r_inp;
  end

  acc_flags #(.W(W)) u_flags (.ac(ac_nx), .e(e_nx), .flags(flg_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q  <= '0;
      e_q   <= 1'b0;
      flg_q <= '{pos: 1'b1, neg: 1'b0, acz: 1'b1, ez: 1'b1};
    end else begin
      ac_q  <= ac_nx;
      e_q   <= e_nx;
      flg_q <= flg_nx;
    end
  end

  assign ac_out   = ac_q;
  assign e_out    = e_q;
  assign flag_pos = flg_q.pos;
  assign flag_neg = flg_q.neg;
  assign flag_acz = flg_q.acz;
  assign flag_ez  = flg_q.ez;
endmodule

// File: rtl/acc_logic_unit_chk.sv
module acc_logic_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic [acc_pkg::NUM_OPS-1:0] op_cmd,
  input logic [W-1:0]                dr_in,
  input logic [W-1:0]                ac_out,
  input logic                        e_out,
  input logic                        flag_pos,
  input logic                        flag_neg,
  input logic                        flag_acz,
  input logic                        flag_ez
);
  import acc_pkg::*;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ac_out == '0) && !e_out);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (op_cmd == '0) |=> $stable(ac_out) && $stable(e_out));

  p_ror_r5: assert property (@(posedge clk) disable iff (rst)
    op_cmd[OP_ROR] |=> (e_out == $past(ac_out[0])) &&
                       (ac_out == {$past(e_out), $past(ac_out[W-1:1])}));

  p_inc_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    op_cmd[OP_INC] |=> (ac_out == W'($past(ac_out) + 1'b1)) && $stable(e_out));

  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    op_cmd[OP_LOAD] |=> (ac_out == $past(dr_in)));

  p_flags_r12: assert property (@(posedge clk) disable iff (rst)
    (flag_acz == (ac_out == '0)) && (flag_ez == !e_out) &&
    (flag_neg == ac_out[W-1]) && (flag_pos == !ac_out[W-1]));

  p_onehot_cmd_r13: assert property (@(posedge clk) disable iff (rst)
    $onehot0(op_cmd));
endmodule

bind acc_logic_unit acc_logic_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_cmd(op_cmd), .dr_in(dr_in),
  .ac_out(ac_out), .e_out(e_out), .flag_pos(flag_pos), .flag_neg(flag_neg),
  .flag_acz(flag_acz), .flag_ez(flag_ez)
);

// File: tb/acc_logic_unit_tb.sv
`timescale 1ns/1ps
module acc_logic_unit_tb;
  localparam int W  = 16;
  localparam int IW = 8;
  localparam int NO = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NO-1:0] op_cmd = '0;
  logic [W-1:0]  dr_in = '0;
  logic [IW-1:0] inp_in = '0;
  logic [W-1:0]  ac_out;
  logic          e_out, flag_pos, flag_neg, flag_acz, flag_ez;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W-1:0] ac;
    logic         e;
    string        tag;
  } exp_t;
  exp_t sb[$];

  logic [W-1:0] m_ac = '0;
  logic         m_e  = 1'b0;

  always #2 clk = ~clk;

  acc_logic_unit #(.W(W), .IW(IW)) u_dut (
    .clk(clk), .rst(rst), .op_cmd(op_cmd), .dr_in(dr_in), .inp_in(inp_in),
    .ac_out(ac_out), .e_out(e_out), .flag_pos(flag_pos), .flag_neg(flag_neg),
    .flag_acz(flag_acz), .flag_ez(flag_ez)
  );

  task automatic check_state(input string tag, input logic [W-1:0] eac, input logic ee);
    logic [4:0] act, exp;
    act = {e_out, flag_pos, flag_neg, flag_acz, flag_ez};
    exp = {ee, ~eac[W-1], eac[W-1], (eac == '0), ~ee};
    checks++;
    if (ac_out !== eac || act !== exp) begin
      errors++;
      $display("FAIL %s: ac=%h e/pos/neg/acz/ez=%b expected ac=%h %b",
               tag, ac_out, act, eac, exp);
    end
  endtask

  // Driver: apply one command (bit index, or -1 for none) and push the model result.
  task automatic run_op(input int b, input logic [W-1:0] d, input logic [IW-1:0] ib,
                        input string tag);
    logic [W:0] s;
    exp_t it;
    @(negedge clk);
    op_cmd = (b < 0) ? '0 : (NO'(1) << b);
    dr_in  = d;
    inp_in = ib;
    case (b)
      0: m_ac = '0;
      1: m_e = 1'b0;
      2: m_ac = ~m_ac;
      3: m_e = ~m_e;
      4: begin s = {m_ac[0], m_e, m_ac[W-1:1]}; m_e = s[W]; m_ac = s[W-1:0]; end
      5: begin s = {m_ac, m_e}; m_e = s[W]; m_ac = s[W-1:0]; end
      6: m_ac = m_ac + 1'b1;
      7: m_ac = m_ac & d;
      8: begin s = {1'b0, m_ac} + {1'b0, d}; m_ac = s[W-1:0]; m_e = s[W]; end
      9: m_ac = d;
      10: m_ac[IW-1:0] = ib;
      default: ;
    endcase
    it.ac = m_ac; it.e = m_e; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: the result of a command sampled at an edge is visible just after it.
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      check_state(it.tag, it.ac, it.e);
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Preload nonzero state, then reset to check R1.
    repeat (2) @(negedge clk);
    rst = 1'b0;
    op_cmd = NO'(1) << 9; dr_in = 16'hA5A5;
    @(negedge clk);
    op_cmd = NO'(1) << 3;
    @(negedge clk);
    op_cmd = '0; rst = 1'b1;
    @(negedge clk);
    check_state("R1 reset", '0, 1'b0);
    rst = 1'b0;

    run_op(9,  16'h8001, 8'h00, "R10 load");
    run_op(4,  16'h0000, 8'h00, "R5 rotate right");
    run_op(4,  16'h0000, 8'h00, "R5 rotate right e in");
    run_op(5,  16'h0000, 8'h00, "R6 rotate left");
    run_op(5,  16'h0000, 8'h00, "R6 rotate left e in");
    run_op(3,  16'h0000, 8'h00, "R4 complement e");
    run_op(2,  16'h0000, 8'h00, "R4 complement ac");
    run_op(-1, 16'hFFFF, 8'hFF, "R2 hold");
    run_op(6,  16'h0000, 8'h00, "R7 increment");
    run_op(7,  16'h0F0F, 8'h00, "R8 and");
    run_op(9,  16'hFFFF, 8'h00, "R10 load ones");
    run_op(6,  16'h0000, 8'h00, "R7 increment wrap");
    run_op(9,  16'h7FFF, 8'h00, "R10 load");
    run_op(8,  16'h0001, 8'h00, "R9 add no carry");
    run_op(8,  16'h8000, 8'h00, "R9 add carry to zero");
    run_op(8,  16'h1234, 8'h00, "R9 add clears carry");
    run_op(10, 16'h0000, 8'h5C, "R11 input low byte");
    run_op(3,  16'h0000, 8'h00, "R4 complement e set");
    run_op(1,  16'h0000, 8'h00, "R3 clear e");
    run_op(0,  16'h0000, 8'h00, "R3 clear ac");
    run_op(-1, 16'h1111, 8'h22, "R2 hold zero R12 flags");
    run_op(9,  16'hC3C3, 8'h00, "R13 single command");
    @(negedge clk);
    op_cmd = '0;
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: pending=%0d expected=0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule